// File: doc/BRIEF.md
# Dual-Channel Speed and Direction Decoder

The block watches a multipole target moving past two sensing points a fixed distance apart. Each point delivers a signed field sample, and both arrive together under one valid strobe. A hysteresis comparator for each channel turns its sample into a binary state. The comparator switches on at a positive operate level and switches off at a negative release level. Between the two levels it keeps its previous state.

The order in which the two channel states change gives the direction of motion. The speed output toggles once for every transition of channel A, so it completes one full period per pole pair. Each speed edge is held back by a programmable number of clock cycles. Any direction update that belongs to that edge therefore appears first and is stable before the edge.

After reset, a power-on interval of a fixed number of cycles runs first. During that interval both outputs stay low and all samples are ignored.

Top module: `speed_dir_decoder`

## Requirements
- R1: When a valid sample is greater than or equal to `thr_on`, that channel's comparator state becomes 1.
- R2: When a valid sample is less than or equal to `thr_off`, that channel's comparator state becomes 0.
- R3: A sample strictly between `thr_off` and `thr_on` leaves the comparator state unchanged, and neither output moves.
- R4: `speed_o` toggles exactly once for each state change of channel A and never for a change of channel B alone. Over one full field period it toggles twice.
- R5: When one channel changes and its new state differs from the other channel, that channel leads. If A leads, `dir_o` is 0 (motion from A toward B). If B leads, `dir_o` is 1.
- R6: When a channel changes to the same state that the other channel already holds, the other channel led. On a reversal, where one channel toggles twice with no change on the other, `dir_o` flips accordingly.
- R7: `dir_o` holds its value when no comparator changes. It also holds when both channels change on the same sample.
- R8: From reset until PON_CYCLES cycles have passed, `speed_o` and `dir_o` are 0 and samples have no effect on the comparators.
- R9: A channel change caused by a sample accepted at clock edge e0 updates `dir_o` at edge e0+1 and toggles `speed_o` (for channel A) at edge e0+1+L, where L = `lead_cyc`. A value of 0 in `lead_cyc` acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Both field samples are valid this cycle |
| field_a | input | FW | Signed field sample, channel A |
| field_b | input | FW | Signed field sample, channel B |
| thr_on | input | FW | Signed operate threshold |
| thr_off | input | FW | Signed release threshold |
| lead_cyc | input | LW | Direction-to-speed lead, in clock cycles |
| speed_o | output | 1 | Speed output, toggles per channel-A transition |
| dir_o | output | 1 | Direction output, 0 = A toward B, 1 = B toward A |

## Verification
The bench drives a sample at a falling edge and records the cycle number, v, seen at that falling edge. The sample is taken at the next rising edge, where the comparator changes. `dir_o` is due at cycle v+2 and `speed_o` at cycle v+2+L. A monitor stamps every output change with its cycle number, and the checks compare those stamps against the expected values. Samples are spaced 160 cycles apart, so each result has settled before the checks read the edge counts and output levels. The idle interval is measured from the release of reset, and samples sent during it must produce no change.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  typedef enum logic {DIR_A2B = 1'b0, DIR_B2A = 1'b1} dir_e;
  localparam int NCH = 2;
endpackage

// File: rtl/hyst_cmp.sv
module hyst_cmp #(
  parameter int FW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic                 vld_i,
  input  logic signed [FW-1:0] field_i,
  input  logic signed [FW-1:0] thr_on_i,
  input  logic signed [FW-1:0] thr_off_i,
  output logic                 state_o,
  output logic                 chg_o
);
  logic reach_on, reach_off;
  assign reach_on  = (field_i >= thr_on_i);
  assign reach_off = (field_i <= thr_off_i);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      state_o <= 1'b0;
      chg_o   <= 1'b0;
    end else begin
      chg_o <= 1'b0;
      if (vld_i) begin
        if (reach_on && !state_o) begin
          state_o <= 1'b1;
          chg_o   <= 1'b1;
        end else if (!reach_on && reach_off && state_o) begin
          state_o <= 1'b0;
          chg_o   <= 1'b1;
        end
      end
    end
  end

  // R1: operate level reached sets the state
  a_r1_operate: assert property (@(posedge clk) disable iff (rst)
    en_i && vld_i && reach_on |=> state_o);
  // R2: release level reached clears the state
  a_r2_release: assert property (@(posedge clk) disable iff (rst)
    en_i && vld_i && reach_off && !reach_on |=> !state_o);
  // R3: nothing reached, nothing changes
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    en_i && !(vld_i && (reach_on || reach_off)) |=> $stable(state_o));
endmodule

// File: rtl/dir_track.sv
module dir_track
  import sdd_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           en_i,
  input  logic [NCH-1:0] chg_i,
  input  logic [NCH-1:0] st_i,
  output logic           dir_o
);
  logic differ;
  assign differ = (st_i[0] != st_i[1]);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      dir_o <= DIR_A2B;
    end else begin
      unique case (chg_i)
        2'b01:   dir_o <= differ ? DIR_A2B : DIR_B2A;
        2'b10:   dir_o <= differ ? DIR_B2A : DIR_A2B;
        default: dir_o <= dir_o;
      endcase
    end
  end

  // R5: channel A moving away from B's state means A leads
  a_r5_a_leads: assert property (@(posedge clk) disable iff (rst)
    en_i && chg_i == 2'b01 && differ |=> dir_o == DIR_A2B);
  // R6: channel A catching up with B means B led
  a_r6_a_follows: assert property (@(posedge clk) disable iff (rst)
    en_i && chg_i == 2'b01 && !differ |=> dir_o == DIR_B2A);
  // R7: simultaneous or absent change keeps the direction
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    en_i && (chg_i == 2'b11 || chg_i == 2'b00) |=> $stable(dir_o));
endmodule

// File: rtl/edge_delay.sv
module edge_delay #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          trig_i,
  input  logic [LW-1:0] lead_i,
  output logic          out_o
);
  logic          pend;
  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      pend  <= 1'b0;
      cnt   <= '0;
      out_o <= 1'b0;
    end else if (trig_i) begin
      pend <= 1'b1;
      cnt  <= (lead_i == '0) ? '0 : lead_i - 1'b1;
    end else if (pend) begin
      if (cnt == '0) begin
        out_o <= ~out_o;
        pend  <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R9: the edge never follows its trigger in the same cycle
  a_r9_no_early: assert property (@(posedge clk) disable iff (rst)
    en_i && trig_i |=> $stable(out_o));
  // R9: while the count runs the output waits
  a_r9_wait: assert property (@(posedge clk) disable iff (rst)
    en_i && !trig_i && pend && cnt != '0 |=> $stable(out_o) && pend);
endmodule

// File: rtl/speed_dir_decoder.sv
module speed_dir_decoder
  import sdd_pkg::*;
#(
  parameter int FW         = 16,
  parameter int LW         = 8,
  parameter int PON_CYCLES = 650
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic signed [FW-1:0] field_a,
  input  logic signed [FW-1:0] field_b,
  input  logic signed [FW-1:0] thr_on,
  input  logic signed [FW-1:0] thr_off,
  input  logic [LW-1:0]        lead_cyc,
  output logic                 speed_o,
  output logic                 dir_o
);
  localparam int PCW = $clog2(PON_CYCLES + 2);

  logic [PCW-1:0]        pon_cnt;
  logic                  ready;
  logic signed [FW-1:0]  fld [NCH];
  logic [NCH-1:0]        st, chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pon_cnt <= '0;
      ready   <= 1'b0;
    end else if (!ready) begin
      pon_cnt <= pon_cnt + 1'b1;
      ready   <= (pon_cnt == PCW'(PON_CYCLES));
    end
  end

  assign fld[0] = field_a;
  assign fld[1] = field_b;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    hyst_cmp #(.FW(FW)) cmp_i (
      .clk       (clk),
      .rst       (rst),
      .en_i      (ready),
      .vld_i     (smp_vld),
      .field_i   (fld[g]),
      .thr_on_i  (thr_on),
      .thr_off_i (thr_off),
      .state_o   (st[g]),
      .chg_o     (chg[g])
    );
  end

  dir_track dir_i (
    .clk   (clk),
    .rst   (rst),
    .en_i  (ready),
    .chg_i (chg),
    .st_i  (st),
    .dir_o (dir_o)
  );

  edge_delay #(.LW(LW)) spd_i (
    .clk    (clk),
    .rst    (rst),
    .en_i   (ready),
    .trig_i (chg[0]),
    .lead_i (lead_cyc),
    .out_o  (speed_o)
  );

  // R8: idle level during the power-on interval
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !speed_o && !dir_o);
  // R9: direction never moves on the cycle a speed edge appears
  a_r9_dir_first: assert property (@(posedge clk) disable iff (rst)
    !$stable(speed_o) |-> $stable(dir_o));
  // R4: a channel-B-only change never starts a speed edge
  a_r4_b_only: assert property (@(posedge clk) disable iff (rst)
    ready && chg == 2'b10 && !$stable(st[1]) |-> $stable(st[0]));
endmodule

// File: tb/speed_dir_decoder_tb_top.sv
`timescale 1ns/1ps
module speed_dir_decoder_tb_top;
  localparam int FW = 16, LW = 8, PON = 650, GAP = 160;

  logic clk = 1'b0, rst = 1'b1, smp_vld = 1'b0;
  logic signed [FW-1:0] field_a = '0, field_b = '0;
  logic signed [FW-1:0] thr_on = 16'sd75, thr_off = -16'sd75;
  logic [LW-1:0] lead_cyc = 8'd10;
  logic speed_o, dir_o;

  int cyc = 0, sp_cnt = 0, dr_cnt = 0, sp_cyc = 0, dr_cyc = 0;
  int checks = 0, errs = 0;
  logic prev_sp = 1'b0, prev_dr = 1'b0;
  bit done = 1'b0;

  speed_dir_decoder #(.FW(FW), .LW(LW), .PON_CYCLES(PON)) dut_i (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .field_a(field_a),
    .field_b(field_b), .thr_on(thr_on), .thr_off(thr_off),
    .lead_cyc(lead_cyc), .speed_o(speed_o), .dir_o(dir_o));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (speed_o !== prev_sp) begin sp_cnt++; sp_cyc = cyc; end
    if (dir_o !== prev_dr) begin dr_cnt++; dr_cyc = cyc; end
    prev_sp = speed_o;
    prev_dr = dir_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int lead);
    lead_cyc = LW'(lead);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (PON + 10) @(negedge clk);
  endtask

  task automatic send(input int a, input int b, output int vc);
    @(negedge clk);
    smp_vld = 1'b1;
    field_a = FW'(a);
    field_b = FW'(b);
    vc = cyc;
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (GAP - 2) @(negedge clk);
  endtask

  task automatic t_power_on;
    int vc, s0;
    lead_cyc = 8'd4;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    s0 = sp_cnt;
    send(200, 200, vc);
    chk(speed_o == 1'b0 && dir_o == 1'b0, "R8 idle outputs", {speed_o, dir_o}, 0);
    repeat (PON) @(negedge clk);
    chk(sp_cnt == s0, "R8 sample ignored in idle", sp_cnt - s0, 0);
    chk(dir_o == 1'b0, "R8 dir after idle", dir_o, 0);
    send(200, 0, vc);
    chk(sp_cnt == s0 + 1, "R8 comparator not latched in idle", sp_cnt - s0, 1);
  endtask

  task automatic t_thresholds;
    int vc, s0, d0;
    do_reset(5);
    s0 = sp_cnt;
    d0 = dr_cnt;
    send(75, 0, vc);
    chk(sp_cnt == s0 + 1, "R1 equal to operate level", sp_cnt - s0, 1);
    chk(sp_cyc == vc + 7, "R9 speed latency L=5", sp_cyc - vc, 7);
    send(74, 0, vc);
    chk(sp_cnt == s0 + 1, "R3 just below operate", sp_cnt - s0, 1);
    send(-74, 0, vc);
    chk(sp_cnt == s0 + 1 && speed_o == 1'b1, "R3 just above release", sp_cnt - s0, 1);
    chk(dr_cnt == d0, "R3 dir unmoved", dr_cnt - d0, 0);
    send(-75, 0, vc);
    chk(sp_cnt == s0 + 2 && speed_o == 1'b0, "R2 equal to release", sp_cnt - s0, 2);
    chk(dir_o == 1'b1, "R6 A falls back to B state", dir_o, 1);
    chk(dr_cyc == vc + 2, "R9 dir latency", dr_cyc - vc, 2);
    chk(sp_cyc - dr_cyc == 5, "R9 lead of dir over speed", sp_cyc - dr_cyc, 5);
  endtask

  task automatic t_sine(input bit b_leads, input string tag);
    int vc, s0, d0;
    real th, p, q;
    do_reset(10);
    s0 = sp_cnt;
    d0 = dr_cnt;
    for (int i = 0; i < 48; i++) begin
      th = 2.0 * 3.14159265358979 * i / 16.0;
      p = 200.0 * $sin(th);
      q = 200.0 * $sin(th - 3.14159265358979 / 2.0);
      if (b_leads) send($rtoi(q), $rtoi(p), vc);
      else         send($rtoi(p), $rtoi(q), vc);
    end
    chk(sp_cnt - s0 == 6, {"R4 speed edges ", tag}, sp_cnt - s0, 6);
    chk(dir_o == b_leads, {"R5 dir polarity ", tag}, dir_o, int'(b_leads));
    chk(dr_cnt - d0 == int'(b_leads), {"R5 dir changes ", tag}, dr_cnt - d0, int'(b_leads));
  endtask

  task automatic t_reversal;
    int vc, s0;
    do_reset(10);
    send(200, 0, vc);
    send(200, 200, vc);
    chk(dir_o == 1'b0, "R5 forward before reversal", dir_o, 0);
    s0 = sp_cnt;
    send(200, -200, vc);
    chk(dir_o == 1'b1 && dr_cyc == vc + 2, "R6 reversal on B", dr_cyc - vc, 2);
    chk(sp_cnt == s0, "R4 B-only change no speed edge", sp_cnt - s0, 0);
    send(-200, -200, vc);
    chk(sp_cnt == s0 + 1 && sp_cyc == vc + 12, "R4 speed after reversal", sp_cyc - vc, 12);
    chk(dir_o == 1'b1, "R6 dir kept after reversal", dir_o, 1);
  endtask

  task automatic t_simul;
    int vc, s0, d0;
    do_reset(3);
    s0 = sp_cnt;
    d0 = dr_cnt;
    send(200, 200, vc);
    chk(sp_cnt == s0 + 1 && dr_cnt == d0, "R7 both rise together", dr_cnt - d0, 0);
    send(0, 0, vc);
    chk(dr_cnt == d0 && sp_cnt == s0 + 1, "R7 no transitions hold", dr_cnt - d0, 0);
    send(200, -200, vc);
    chk(dir_o == 1'b1, "R6 B leads toward A", dir_o, 1);
    d0 = dr_cnt;
    send(-200, 200, vc);
    chk(dr_cnt == d0 && dir_o == 1'b1, "R7 both change together", dr_cnt - d0, 0);
    chk(sp_cnt == s0 + 2, "R4 speed on joint change", sp_cnt - s0, 2);
  endtask

  task automatic t_lead_zero;
    int vc;
    do_reset(0);
    send(200, 0, vc);
    chk(sp_cyc == vc + 3, "R9 zero lead acts as one", sp_cyc - vc, 3);
  endtask

  initial begin
    t_power_on();
    t_thresholds();
    t_sine(1'b0, "A to B");
    t_sine(1'b1, "B to A");
    t_reversal();
    t_simul();
    t_lead_zero();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule